// File: doc/BRIEF.md
# 64-bit Logical, Shift and Conditional-Move Unit

This is an integer execution unit for a 64-bit RISC pipeline. It covers three kinds of operation. The first kind is bitwise logic, including forms that complement the second operand. The second is logical and arithmetic shifts by a variable count. The third is predicated moves whose condition is evaluated on operand A alone.

Each operation takes operand A, operand B and the current value of the destination register. Operand B is either a register value or an immediate that has already been extended to 64 bits. The unit returns a result and a write-enable. When a conditional move's predicate fails, the write-enable is low and the result carries the old destination value, so the register keeps its contents.

The result is registered in one output stage. That stage is loaded whenever `in_valid_i` is high, and `out_valid_o` marks the cycle that follows.

Top module: `lsc_unit`

## Requirements
- R1: The logical codes on `op_i` are 0 = A&B, 1 = A&~B, 2 = A|B, 3 = A^~B, 4 = A|~B and 5 = A^B.
- R2: Code 8 moves when A is zero. Code 9 moves when A is nonzero.
- R3: Codes 10 (A<0), 11 (A>=0), 12 (A<=0) and 13 (A>0) move when the stated comparison holds, with A taken as a signed 64-bit value.
- R4: Code 14 moves when bit 0 of A is 0. Code 15 moves when bit 0 of A is 1.
- R5: For a conditional move whose predicate holds, the result is B and `wr_en_o` is 1. When the predicate fails, the result is `dst_i` and `wr_en_o` is 0.
- R6: A shift uses only B[5:0] as its count. A B of 64 therefore behaves as a count of 0.
- R7: Code 16 (shift left) and code 17 (logical shift right) fill the vacated bits with zeros.
- R8: Code 18 (arithmetic shift right) fills the vacated upper bits with A[63]. A count of 0 returns A unchanged.
- R9: Codes 6, 7 and 19 to 31 give a result of 0 with `wr_en_o` at 0.
- R10: Every logical code and every shift code sets `wr_en_o` to 1.
- R11: `out_valid_o` is 1 in the cycle after a cycle with `in_valid_i` high, and 0 otherwise. Reset clears `out_valid_o`, `result_o` and `wr_en_o`.
- R12: While `in_valid_i` is low, `result_o` and `wr_en_o` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Operation present this cycle |
| op_i | input | 5 | Operation code |
| a_i | input | 64 | Operand A |
| b_i | input | 64 | Operand B or extended immediate |
| dst_i | input | 64 | Current destination value |
| out_valid_o | output | 1 | Result valid |
| result_o | output | 64 | Registered result |
| wr_en_o | output | 1 | Destination write-enable |

## Verification
Every result, write-enable and valid flag is due exactly one rising edge after the operation is presented. The bench drives each operation on a falling edge and compares outputs on the next falling edge. That comparison therefore lands half a cycle after the single register stage has loaded. Hold behaviour is checked the same way: one cycle with `in_valid_i` low and changed operands, then a check on the following falling edge that the outputs did not move.

// File: rtl/lsc_pkg.sv
package lsc_pkg;
  localparam int unsigned OP_W = 5;

  typedef enum logic [OP_W-1:0] {
    OP_AND  = 5'd0,  OP_ANDN = 5'd1,  OP_OR   = 5'd2,  OP_XNOR = 5'd3,
    OP_ORN  = 5'd4,  OP_XOR  = 5'd5,
    OP_CEQ  = 5'd8,  OP_CNE  = 5'd9,  OP_CLT  = 5'd10, OP_CGE  = 5'd11,
    OP_CLE  = 5'd12, OP_CGT  = 5'd13, OP_CLBC = 5'd14, OP_CLBS = 5'd15,
    OP_SLL  = 5'd16, OP_SRL  = 5'd17, OP_SRA  = 5'd18
  } op_e;

  typedef enum logic [1:0] {CLS_LOGIC, CLS_CMOV, CLS_SHIFT, CLS_NONE} cls_e;

  typedef enum logic [1:0] {SH_LEFT, SH_RIGHT, SH_ARITH, SH_RSVD} sh_e;
endpackage

// File: rtl/lsc_logic.sv
module lsc_logic #(
  parameter int unsigned DATA_W = 64
) (
  input  logic [2:0]        fn_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  output logic [DATA_W-1:0] y_o
);
  logic [DATA_W-1:0] b_n;
  assign b_n = ~b_i;

  always_comb begin
    unique case (fn_i)
      3'd0:    y_o = a_i & b_i;
      3'd1:    y_o = a_i & b_n;
      3'd2:    y_o = a_i | b_i;
      3'd3:    y_o = a_i ^ b_n;
      3'd4:    y_o = a_i | b_n;
      3'd5:    y_o = a_i ^ b_i;
      default: y_o = '0;
    endcase
  end
endmodule

// File: rtl/lsc_cmov.sv
module lsc_cmov #(
  parameter int unsigned DATA_W = 64
) (
  input  logic [2:0]        fn_i,
  input  logic [DATA_W-1:0] a_i,
  output logic              take_o
);
  logic is_zero, is_neg;
  assign is_zero = ~|a_i;
  assign is_neg  = a_i[DATA_W-1];

  always_comb begin
    unique case (fn_i)
      3'd0: take_o = is_zero;
      3'd1: take_o = ~is_zero;
      3'd2: take_o = is_neg;
      3'd3: take_o = ~is_neg;
      3'd4: take_o = is_neg | is_zero;
      3'd5: take_o = ~is_neg & ~is_zero;
      3'd6: take_o = ~a_i[0];
      3'd7: take_o = a_i[0];
      default: take_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/lsc_shift.sv
module lsc_shift
  import lsc_pkg::*;
#(
  parameter int unsigned DATA_W = 64,
  localparam int unsigned CNT_W = $clog2(DATA_W)
) (
  input  sh_e               kind_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [CNT_W-1:0]  cnt_i,
  output logic [DATA_W-1:0] y_o
);
  logic              left;
  logic              fill;
  logic [DATA_W-1:0] a_rev;
  logic [DATA_W-1:0] src;
  logic [DATA_W-1:0] stage [CNT_W+1];

  assign left = (kind_i == SH_LEFT);
  assign fill = (kind_i == SH_ARITH) & a_i[DATA_W-1];

  always_comb begin
    for (int i = 0; i < DATA_W; i++) a_rev[i] = a_i[DATA_W-1-i];
  end

  // Left shift = reverse, right shift, reverse back.
  assign src      = left ? a_rev : a_i;
  assign stage[0] = src;

  // Log stages: largest single step is DATA_W/2, never a full-width shift.
  for (genvar k = 0; k < CNT_W; k++) begin : g_stage
    localparam int unsigned STEP = 1 << k;
    assign stage[k+1] = cnt_i[k] ? {{STEP{fill}}, stage[k][DATA_W-1:STEP]} : stage[k];
  end

  always_comb begin
    for (int i = 0; i < DATA_W; i++)
      y_o[i] = left ? stage[CNT_W][DATA_W-1-i] : stage[CNT_W][i];
  end
endmodule

// File: rtl/lsc_unit.sv
module lsc_unit
  import lsc_pkg::*;
#(
  parameter int unsigned DATA_W = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_valid_i,
  input  logic [4:0]        op_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic [DATA_W-1:0] dst_i,
  output logic              out_valid_o,
  output logic [DATA_W-1:0] result_o,
  output logic              wr_en_o
);
  localparam int unsigned CNT_W = $clog2(DATA_W);

  cls_e              cls;
  sh_e               sh_kind;
  logic [DATA_W-1:0] logic_y, shift_y;
  logic              take;
  logic [DATA_W-1:0] res_d;
  logic              we_d;

  always_comb begin
    if (op_i[4:3] == 2'b00 && op_i[2:0] <= 3'd5)      cls = CLS_LOGIC;
    else if (op_i[4:3] == 2'b01)                       cls = CLS_CMOV;
    else if (op_i[4:2] == 3'b100 && op_i[1:0] != 2'b11) cls = CLS_SHIFT;
    else                                               cls = CLS_NONE;
  end

  assign sh_kind = sh_e'(op_i[1:0]);

  lsc_logic #(.DATA_W(DATA_W)) u_logic (
    .fn_i (op_i[2:0]),
    .a_i  (a_i),
    .b_i  (b_i),
    .y_o  (logic_y)
  );

  lsc_cmov #(.DATA_W(DATA_W)) u_cmov (
    .fn_i   (op_i[2:0]),
    .a_i    (a_i),
    .take_o (take)
  );

  lsc_shift #(.DATA_W(DATA_W)) u_shift (
    .kind_i (sh_kind),
    .a_i    (a_i),
    .cnt_i  (b_i[CNT_W-1:0]),
    .y_o    (shift_y)
  );

  always_comb begin
    unique case (cls)
      CLS_LOGIC: begin res_d = logic_y;               we_d = 1'b1; end
      CLS_CMOV:  begin res_d = take ? b_i : dst_i;    we_d = take; end
      CLS_SHIFT: begin res_d = shift_y;               we_d = 1'b1; end
      default:   begin res_d = '0;                    we_d = 1'b0; end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_o <= 1'b0;
      result_o    <= '0;
      wr_en_o     <= 1'b0;
    end else begin
      out_valid_o <= in_valid_i;
      if (in_valid_i) begin
        result_o <= res_d;
        wr_en_o  <= we_d;
      end
    end
  end
endmodule

// File: rtl/lsc_unit_chk.sv
module lsc_unit_chk #(
  parameter int unsigned DATA_W = 64
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              in_valid_i,
  input logic [4:0]        op_i,
  input logic [DATA_W-1:0] a_i,
  input logic [DATA_W-1:0] b_i,
  input logic [DATA_W-1:0] dst_i,
  input logic              out_valid_o,
  input logic [DATA_W-1:0] result_o,
  input logic              wr_en_o
);
  p_valid_set_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i |=> out_valid_o);
  p_valid_clr_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_valid_i |=> !out_valid_o);
  p_hold_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_valid_i |=> ($stable(result_o) && $stable(wr_en_o)));
  p_unused_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && (op_i > 5'd18 || op_i == 5'd6 || op_i == 5'd7))
    |=> (result_o == '0 && !wr_en_o));
  p_cmov_src_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && op_i[4:3] == 2'b01)
    |=> (wr_en_o ? (result_o == $past(b_i)) : (result_o == $past(dst_i))));
  p_eq_take_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && op_i == 5'd8 && a_i == '0) |=> wr_en_o);
  p_we_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && (op_i <= 5'd5 || (op_i >= 5'd16 && op_i <= 5'd18))) |=> wr_en_o);
  p_sra_zero_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && op_i == 5'd18 && b_i[5:0] == 6'd0) |=> (result_o == $past(a_i)));
endmodule

bind lsc_unit lsc_unit_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .in_valid_i  (in_valid_i),
  .op_i        (op_i),
  .a_i         (a_i),
  .b_i         (b_i),
  .dst_i       (dst_i),
  .out_valid_o (out_valid_o),
  .result_o    (result_o),
  .wr_en_o     (wr_en_o)
);

// File: tb/lsc_unit_tb.sv
module lsc_unit_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        in_valid_i = 1'b0;
  logic [4:0]  op_i = '0;
  logic [63:0] a_i = '0, b_i = '0, dst_i = '0;
  logic        out_valid_o;
  logic [63:0] result_o;
  logic        wr_en_o;

  int n_checks = 0;
  int n_errors = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  lsc_unit u_dut (
    .clk_i (clk_i), .rst_ni (rst_ni), .in_valid_i (in_valid_i), .op_i (op_i),
    .a_i (a_i), .b_i (b_i), .dst_i (dst_i),
    .out_valid_o (out_valid_o), .result_o (result_o), .wr_en_o (wr_en_o)
  );

  function automatic string req_of(input logic [4:0] op);
    if (op <= 5) return "R1";
    if (op == 8 || op == 9) return "R2";
    if (op >= 10 && op <= 13) return "R3";
    if (op == 14 || op == 15) return "R4";
    if (op == 16 || op == 17) return "R7";
    if (op == 18) return "R8";
    return "R9";
  endfunction

  function automatic logic cond_of(input logic [4:0] op, input logic [63:0] a);
    case (op)
      8:  return a == 0;
      9:  return a != 0;
      10: return $signed(a) < 0;
      11: return $signed(a) >= 0;
      12: return $signed(a) <= 0;
      13: return $signed(a) > 0;
      14: return a[0] == 1'b0;
      15: return a[0] == 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic [64:0] model(input logic [4:0] op, input logic [63:0] a,
                                        input logic [63:0] b, input logic [63:0] d);
    int sh;
    sh = int'(b[5:0]);
    case (op)
      0:  return {1'b1, a & b};
      1:  return {1'b1, a & ~b};
      2:  return {1'b1, a | b};
      3:  return {1'b1, ~(a ^ b)};
      4:  return {1'b1, a | ~b};
      5:  return {1'b1, a ^ b};
      16: return {1'b1, a << sh};
      17: return {1'b1, a >> sh};
      18: return {1'b1, 64'($signed(a) >>> sh)};
      8, 9, 10, 11, 12, 13, 14, 15:
        return cond_of(op, a) ? {1'b1, b} : {1'b0, d};
      default: return 65'd0;
    endcase
  endfunction

  task automatic check(input string req, input logic [64:0] act, input logic [64:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: got we=%0b res=%h expected we=%0b res=%h",
               req, act[64], act[63:0], exp[64], exp[63:0]);
    end
  endtask

  task automatic run_op(input logic [4:0] op, input logic [63:0] a,
                        input logic [63:0] b, input logic [63:0] d);
    logic [64:0] e;
    op_i = op; a_i = a; b_i = b; dst_i = d; in_valid_i = 1'b1;
    e = model(op, a, b, d);
    @(negedge clk_i);
    check(req_of(op), {wr_en_o, result_o}, e);
    check("R11", {64'd0, out_valid_o}, 65'd1);
  endtask

  localparam logic [63:0] CORNER [5] = '{64'd0, 64'd1, '1, 64'h8000_0000_0000_0000,
                                         64'h0123_4567_89ab_cdef};
  localparam logic [63:0] COUNTS [5] = '{64'd0, 64'd1, 64'd63, 64'd64, 64'hffff_ffc5};

  initial begin
    #(CLK_PERIOD * 200000);
    n_errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    logic [63:0] hold_r;
    logic        hold_w;
    int unsigned seed;
    seed = 32'd1234;
    void'($urandom(seed));

    repeat (3) @(negedge clk_i);
    // R11: reset state
    check("R11", {out_valid_o, result_o}, 65'd0);
    check("R11", {64'd0, wr_en_o}, 65'd0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R11", {64'd0, out_valid_o}, 65'd0);

    // directed corners over every code
    for (int op = 0; op < 32; op++) begin
      for (int i = 0; i < 5; i++) begin
        for (int j = 0; j < 5; j++) begin
          if (op >= 16 && op <= 18)
            run_op(5'(op), CORNER[i], COUNTS[j], 64'hdead_beef_0000_1111);
          else
            run_op(5'(op), CORNER[i], CORNER[j], 64'hdead_beef_0000_1111);
        end
      end
    end

    // R6: count 64 and upper-bit garbage behave like low six bits
    run_op(5'd16, 64'h00ff, 64'hffff_ff40, '0);
    check("R6", {1'b1, result_o}, {1'b1, 64'h00ff});
    run_op(5'd18, 64'h8000_0000_0000_0000, 64'h7c, '0);
    check("R6", {1'b1, result_o}, {1'b1, 64'hffff_ffff_ffff_fff8});

    // R12: hold while idle with changed operands
    hold_r = result_o; hold_w = wr_en_o;
    in_valid_i = 1'b0; op_i = 5'd2; a_i = '1; b_i = '1; dst_i = 64'h55;
    @(negedge clk_i);
    check("R12", {hold_w, hold_r}, {wr_en_o, result_o});
    check("R11", {64'd0, out_valid_o}, 65'd0);

    // random mix, valid toggling
    for (int n = 0; n < 3000; n++) begin
      logic [4:0]  op;
      logic [63:0] a, b, d;
      op = 5'($urandom_range(0, 31));
      a = {$urandom, $urandom}; b = {$urandom, $urandom}; d = {$urandom, $urandom};
      if (n % 7 == 0) a = '0;
      if (n % 11 == 0) a[63] = 1'b1;
      if ($urandom_range(0, 4) == 0) begin
        hold_r = result_o; hold_w = wr_en_o;
        in_valid_i = 1'b0; op_i = op; a_i = a; b_i = b; dst_i = d;
        @(negedge clk_i);
        check("R12", {wr_en_o, result_o}, {hold_w, hold_r});
      end else begin
        run_op(op, a, b, d);
      end
    end

    in_valid_i = 1'b0;
    @(negedge clk_i);
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule